// File: doc/BRIEF.md
# Row-Aware Bank Request Scheduler

This block sits between a stream of memory requests and a set of DRAM banks that share one data bus. It keeps a short age-ordered queue of pending reads and writes, each naming a bank, a row, a column and a tag. It also tracks for every bank whether a row is open, which row that is, and how long the bank is still occupied. Each cycle it chooses at most one command to send. The choice is a row activate, a precharge, or a read or write column command. The scheduler picks it so that column commands to open rows come first, bank preparation runs alongside data transfers on other banks, and the shared data bus sits idle as little as possible.

A request is finished when its column command is issued. In that same cycle the block pulses a done strobe and returns the request's tag, so tags come back in the order the requests were served, which need not be arrival order. Row activate, precharge and burst lengths and the write-to-read turnaround are parameters. Each request can be overtaken by younger ones only a bounded number of times.

Top module: `rowsched_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmdValid` and `doneValid` are low and `inReady` is high.
- R2: A request to a bank with no open row gets a row activate (`cmdOp` 00). Its column command follows exactly TRCD cycles later, read as `cmdOp` 10 and write as `cmdOp` 11. A column command only goes to a bank whose open row matches the request's row.
- R3: Requests to the open row of one bank get column commands spaced exactly BURST cycles apart, with no activate or precharge between them.
- R4: Requests to two idle banks have their activates issued in consecutive cycles, and their column commands are exactly BURST cycles apart.
- R5: A request to a different row of an open bank gets a precharge (`cmdOp` 01) no sooner than BURST cycles after that bank's last column command. The activate follows exactly TRP cycles after the precharge, and the column command follows TRCD cycles after that.
- R6: A precharge to one bank may issue while a column burst of another bank is still within its BURST-cycle window.
- R7: A read column command follows a write column command by at least BURST+TWTR cycles. A write after a read needs only BURST cycles.
- R8: Selection order is: the oldest ready request that hits an open row, then the oldest ready request to a bank with no open row, then the oldest ready row-conflict request. A conflict request does not precharge a bank while any queued request still hits that bank's open row.
- R9: Once the oldest request has been overtaken MAXBYP times by younger column commands, no other request gets a command until that request's column command has issued.
- R10: `doneValid` pulses for one cycle with the served request's tag in the same cycle as its column command.
- R11: `inReady` is low while the queue holds DEPTH requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | New request present (taken when inReady is high) |
| inWrite | input | 1 | 1 = write, 0 = read |
| inBank | input | $clog2(NBANK) | Target bank |
| inRow | input | ROWW | Target row |
| inCol | input | COLW | Target column |
| inTag | input | TAGW | Request identifier |
| inReady | output | 1 | Queue has a free slot |
| cmdValid | output | 1 | A command is issued this cycle |
| cmdOp | output | 2 | 00 activate, 01 precharge, 10 read, 11 write |
| cmdBank | output | $clog2(NBANK) | Bank of the command |
| cmdRow | output | ROWW | Row of the request the command serves |
| cmdCol | output | COLW | Column of the request the command serves |
| doneValid | output | 1 | A request completed this cycle |
| doneTag | output | TAGW | Tag of the completed request |

## Verification
A stale open-row or bank-busy state shows up at the ports within a few cycles. It appears as an activate or precharge that should not be there, a column command TRCD or TRP cycles early, or a missing precharge before a row change. A wrong data-bus counter shifts the next column command off its exact BURST or BURST+TWTR spacing. That spacing can be measured against the previous column. Errors in the age order or the bypass count show as tags returning in the wrong order, or as a starved read finishing several bursts late. The directed scenarios fix the cycle of every command relative to the push, so one cycle of drift is caught.

// File: rtl/rowsched_pkg.sv
package rowsched_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_PRE = 2'd2,
    CMD_COL = 2'd3
  } cmdKind_t;

  typedef struct packed {
    logic     fire;
    cmdKind_t kind;
  } strobe_t;
endpackage

// File: rtl/rowsched_ctrl.sv
module rowsched_ctrl
  import rowsched_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int NBANK  = 4,
  parameter int ROWW   = 8,
  parameter int MAXBYP = 2,
  localparam int BW  = $clog2(NBANK),
  localparam int IW  = $clog2(DEPTH),
  localparam int BYW = $clog2(MAXBYP + 1)
) (
  input  logic            qValid   [DEPTH],
  input  logic            qWrite   [DEPTH],
  input  logic [BW-1:0]   qBank    [DEPTH],
  input  logic [ROWW-1:0] qRow     [DEPTH],
  input  logic [BYW-1:0]  qByp     [DEPTH],
  input  logic            bankOpen [NBANK],
  input  logic [ROWW-1:0] bankRow  [NBANK],
  input  logic            bankFree [NBANK],
  input  logic            rdOk,
  input  logic            wrOk,
  output strobe_t         stb,
  output logic [IW-1:0]   selIdx
);
  logic             starve;
  logic [DEPTH-1:0] isHit, isIdle, isConf, hitOk, idleOk, confOk;
  logic [NBANK-1:0] hitPend;
  logic             hAny, iAny, cAny;
  logic [IW-1:0]    hSel, iSel, cSel;

  // classify each queued request against its bank's row state
  always_comb begin
    starve  = qValid[0] && (qByp[0] >= BYW'(MAXBYP));
    hitPend = '0;
    for (int i = 0; i < DEPTH; i++) begin
      isHit[i]  = qValid[i] && bankOpen[qBank[i]] && (bankRow[qBank[i]] == qRow[i]);
      isIdle[i] = qValid[i] && !bankOpen[qBank[i]];
      isConf[i] = qValid[i] && bankOpen[qBank[i]] && (bankRow[qBank[i]] != qRow[i]);
      if (isHit[i]) hitPend[qBank[i]] = 1'b1;
    end
    for (int i = 0; i < DEPTH; i++) begin
      logic allowed;
      allowed   = !starve || (i == 0);
      hitOk[i]  = allowed && isHit[i] && bankFree[qBank[i]] && (qWrite[i] ? wrOk : rdOk);
      idleOk[i] = allowed && isIdle[i] && bankFree[qBank[i]];
      confOk[i] = allowed && isConf[i] && bankFree[qBank[i]] &&
                  (!hitPend[qBank[i]] || (starve && i == 0));
    end
  end

  // oldest (lowest index) per class, then class priority
  always_comb begin
    hAny = 1'b0; iAny = 1'b0; cAny = 1'b0;
    hSel = '0;   iSel = '0;   cSel = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hitOk[i])  begin hAny = 1'b1; hSel = IW'(i); end
      if (idleOk[i]) begin iAny = 1'b1; iSel = IW'(i); end
      if (confOk[i]) begin cAny = 1'b1; cSel = IW'(i); end
    end
    stb.fire = hAny || iAny || cAny;
    if (hAny)      begin stb.kind = CMD_COL; selIdx = hSel; end
    else if (iAny) begin stb.kind = CMD_ACT; selIdx = iSel; end
    else if (cAny) begin stb.kind = CMD_PRE; selIdx = cSel; end
    else           begin stb.kind = CMD_NOP; selIdx = '0;   end
  end
endmodule

// File: rtl/rowsched_store.sv
module rowsched_store
  import rowsched_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int NBANK  = 4,
  parameter int ROWW   = 8,
  parameter int COLW   = 6,
  parameter int TAGW   = 8,
  parameter int BURST  = 4,
  parameter int TRCD   = 3,
  parameter int TRP    = 3,
  parameter int TWTR   = 2,
  parameter int MAXBYP = 2,
  localparam int BW  = $clog2(NBANK),
  localparam int IW  = $clog2(DEPTH),
  localparam int BYW = $clog2(MAXBYP + 1),
  localparam int CW  = $clog2(BURST + TWTR + TRCD + TRP + 1),
  localparam int GW  = $clog2(BURST + TWTR + 2) + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic            inWrite,
  input  logic [BW-1:0]   inBank,
  input  logic [ROWW-1:0] inRow,
  input  logic [COLW-1:0] inCol,
  input  logic [TAGW-1:0] inTag,
  input  strobe_t         stb,
  input  logic [IW-1:0]   selIdx,
  output logic            inReady,
  output logic            qValid   [DEPTH],
  output logic            qWrite   [DEPTH],
  output logic [BW-1:0]   qBank    [DEPTH],
  output logic [ROWW-1:0] qRow     [DEPTH],
  output logic [BYW-1:0]  qByp     [DEPTH],
  output logic            bankOpen [NBANK],
  output logic [ROWW-1:0] bankRow  [NBANK],
  output logic            bankFree [NBANK],
  output logic            rdOk,
  output logic            wrOk,
  output logic            cmdValid,
  output logic [1:0]      cmdOp,
  output logic [BW-1:0]   cmdBank,
  output logic [ROWW-1:0] cmdRow,
  output logic [COLW-1:0] cmdCol,
  output logic            doneValid,
  output logic [TAGW-1:0] doneTag
);
  logic [COLW-1:0] qCol [DEPTH];
  logic [TAGW-1:0] qTag [DEPTH];
  logic            nValid [DEPTH];
  logic            nWrite [DEPTH];
  logic [BW-1:0]   nBank  [DEPTH];
  logic [ROWW-1:0] nRow   [DEPTH];
  logic [COLW-1:0] nCol   [DEPTH];
  logic [TAGW-1:0] nTag   [DEPTH];
  logic [BYW-1:0]  nByp   [DEPTH];
  logic [CW-1:0]   bankCnt [NBANK];
  logic [CW-1:0]   busCnt, rdCnt;
  logic [IW:0]     cntQ, tailQ;
  logic            remove;
  logic [BW-1:0]   selBank;
  logic [ROWW-1:0] selRow;
  logic            selWrite;

  assign selBank  = qBank[selIdx];
  assign selRow   = qRow[selIdx];
  assign selWrite = qWrite[selIdx];
  assign remove   = stb.fire && (stb.kind == CMD_COL);
  assign rdOk     = (rdCnt == '0);
  assign wrOk     = (busCnt == '0);

  for (genvar b = 0; b < NBANK; b++) begin : g_free
    assign bankFree[b] = (bankCnt[b] == '0);
  end

  // queue next state: compact out the served entry, append the new one
  always_comb begin
    cntQ = '0;
    for (int i = 0; i < DEPTH; i++) cntQ = cntQ + (IW + 1)'(qValid[i]);
    inReady = (cntQ < (IW + 1)'(DEPTH));
    for (int i = 0; i < DEPTH; i++) begin
      nValid[i] = qValid[i]; nWrite[i] = qWrite[i]; nBank[i] = qBank[i];
      nRow[i] = qRow[i]; nCol[i] = qCol[i]; nTag[i] = qTag[i]; nByp[i] = qByp[i];
      if (remove && i >= int'(selIdx)) begin
        if (i < DEPTH - 1) begin
          nValid[i] = qValid[i+1]; nWrite[i] = qWrite[i+1]; nBank[i] = qBank[i+1];
          nRow[i] = qRow[i+1]; nCol[i] = qCol[i+1]; nTag[i] = qTag[i+1]; nByp[i] = qByp[i+1];
        end else begin
          nValid[i] = 1'b0;
        end
      end else if (remove && qByp[i] < BYW'(MAXBYP)) begin
        nByp[i] = qByp[i] + 1'b1;
      end
    end
    tailQ = cntQ - (IW + 1)'(remove);
    if (inValid && inReady) begin
      nValid[tailQ[IW-1:0]] = 1'b1;   nWrite[tailQ[IW-1:0]] = inWrite;
      nBank[tailQ[IW-1:0]]  = inBank; nRow[tailQ[IW-1:0]]   = inRow;
      nCol[tailQ[IW-1:0]]   = inCol;  nTag[tailQ[IW-1:0]]   = inTag;
      nByp[tailQ[IW-1:0]]   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        qValid[i] <= 1'b0; qWrite[i] <= 1'b0; qBank[i] <= '0;
        qRow[i] <= '0; qCol[i] <= '0; qTag[i] <= '0; qByp[i] <= '0;
      end
      for (int b = 0; b < NBANK; b++) begin
        bankOpen[b] <= 1'b0; bankRow[b] <= '0; bankCnt[b] <= '0;
      end
      busCnt <= '0; rdCnt <= '0;
      cmdValid <= 1'b0; cmdOp <= 2'b00; cmdBank <= '0; cmdRow <= '0; cmdCol <= '0;
      doneValid <= 1'b0; doneTag <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        qValid[i] <= nValid[i]; qWrite[i] <= nWrite[i]; qBank[i] <= nBank[i];
        qRow[i] <= nRow[i]; qCol[i] <= nCol[i]; qTag[i] <= nTag[i]; qByp[i] <= nByp[i];
      end
      for (int b = 0; b < NBANK; b++) begin
        if (stb.fire && selBank == BW'(b)) begin
          case (stb.kind)
            CMD_ACT: begin bankOpen[b] <= 1'b1; bankRow[b] <= selRow; bankCnt[b] <= CW'(TRCD - 1); end
            CMD_PRE: begin bankOpen[b] <= 1'b0; bankCnt[b] <= CW'(TRP - 1); end
            CMD_COL: bankCnt[b] <= CW'(BURST - 1);
            default: ;
          endcase
        end else if (bankCnt[b] != '0) begin
          bankCnt[b] <= bankCnt[b] - 1'b1;
        end
      end
      if (remove) begin
        busCnt <= CW'(BURST - 1);
        rdCnt  <= selWrite ? CW'(BURST + TWTR - 1) : CW'(BURST - 1);
      end else begin
        if (busCnt != '0) busCnt <= busCnt - 1'b1;
        if (rdCnt != '0)  rdCnt  <= rdCnt - 1'b1;
      end
      cmdValid  <= stb.fire;
      cmdOp     <= (stb.kind == CMD_COL) ? {1'b1, selWrite} :
                   (stb.kind == CMD_PRE) ? 2'b01 : 2'b00;
      cmdBank   <= selBank;
      cmdRow    <= selRow;
      cmdCol    <= qCol[selIdx];
      doneValid <= remove;
      doneTag   <= qTag[selIdx];
    end
  end

  // output-side spacing trackers for the checks below
  logic [GW-1:0] colGap, wrGap;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      colGap <= '1; wrGap <= '1;
    end else begin
      if (cmdValid && cmdOp[1]) colGap <= GW'(1);
      else if (colGap != '1)    colGap <= colGap + 1'b1;
      if (cmdValid && cmdOp == 2'b11) wrGap <= GW'(1);
      else if (wrGap != '1)           wrGap <= wrGap + 1'b1;
    end
  end

  assert_col_open_R2: assert property (@(posedge clk) disable iff (!rstN)
    remove |-> (bankOpen[selBank] && bankRow[selBank] == selRow));
  assert_bank_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.fire |-> bankFree[selBank]);
  assert_col_gap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp[1]) |-> (colGap >= GW'(BURST)));
  assert_wr_rd_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'b10) |-> (wrGap >= GW'(BURST + TWTR)));
  assert_starve_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fire && qValid[0] && qByp[0] == BYW'(MAXBYP)) |-> (selIdx == '0));
  assert_done_col_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (cmdValid && cmdOp[1]));
endmodule

// File: rtl/rowsched_top.sv
module rowsched_top
  import rowsched_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int NBANK  = 4,
  parameter int ROWW   = 8,
  parameter int COLW   = 6,
  parameter int TAGW   = 8,
  parameter int BURST  = 4,
  parameter int TRCD   = 3,
  parameter int TRP    = 3,
  parameter int TWTR   = 2,
  parameter int MAXBYP = 2,
  localparam int BW  = $clog2(NBANK),
  localparam int IW  = $clog2(DEPTH),
  localparam int BYW = $clog2(MAXBYP + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic            inWrite,
  input  logic [BW-1:0]   inBank,
  input  logic [ROWW-1:0] inRow,
  input  logic [COLW-1:0] inCol,
  input  logic [TAGW-1:0] inTag,
  output logic            inReady,
  output logic            cmdValid,
  output logic [1:0]      cmdOp,
  output logic [BW-1:0]   cmdBank,
  output logic [ROWW-1:0] cmdRow,
  output logic [COLW-1:0] cmdCol,
  output logic            doneValid,
  output logic [TAGW-1:0] doneTag
);
  strobe_t         stb;
  logic [IW-1:0]   selIdx;
  logic            qValid   [DEPTH];
  logic            qWrite   [DEPTH];
  logic [BW-1:0]   qBank    [DEPTH];
  logic [ROWW-1:0] qRow     [DEPTH];
  logic [BYW-1:0]  qByp     [DEPTH];
  logic            bankOpen [NBANK];
  logic [ROWW-1:0] bankRow  [NBANK];
  logic            bankFree [NBANK];
  logic            rdOk, wrOk;

  rowsched_ctrl #(.DEPTH(DEPTH), .NBANK(NBANK), .ROWW(ROWW), .MAXBYP(MAXBYP)) u_ctrl (
    .qValid(qValid), .qWrite(qWrite), .qBank(qBank), .qRow(qRow), .qByp(qByp),
    .bankOpen(bankOpen), .bankRow(bankRow), .bankFree(bankFree),
    .rdOk(rdOk), .wrOk(wrOk), .stb(stb), .selIdx(selIdx));

  rowsched_store #(.DEPTH(DEPTH), .NBANK(NBANK), .ROWW(ROWW), .COLW(COLW), .TAGW(TAGW),
                   .BURST(BURST), .TRCD(TRCD), .TRP(TRP), .TWTR(TWTR), .MAXBYP(MAXBYP)) u_store (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWrite(inWrite), .inBank(inBank),
    .inRow(inRow), .inCol(inCol), .inTag(inTag), .stb(stb), .selIdx(selIdx),
    .inReady(inReady), .qValid(qValid), .qWrite(qWrite), .qBank(qBank), .qRow(qRow),
    .qByp(qByp), .bankOpen(bankOpen), .bankRow(bankRow), .bankFree(bankFree),
    .rdOk(rdOk), .wrOk(wrOk), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdBank(cmdBank),
    .cmdRow(cmdRow), .cmdCol(cmdCol), .doneValid(doneValid), .doneTag(doneTag));
endmodule

// File: tb/sim_rowsched_top.sv
module sim_rowsched_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0, inWrite = 1'b0;
  logic [1:0] inBank = '0;
  logic [7:0] inRow = '0;
  logic [5:0] inCol = '0;
  logic [7:0] inTag = '0;
  logic       inReady, cmdValid, doneValid;
  logic [1:0] cmdOp, cmdBank;
  logic [7:0] cmdRow, doneTag;
  logic [5:0] cmdCol;

  rowsched_top u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWrite(inWrite), .inBank(inBank),
    .inRow(inRow), .inCol(inCol), .inTag(inTag), .inReady(inReady), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdBank(cmdBank), .cmdRow(cmdRow), .cmdCol(cmdCol),
    .doneValid(doneValid), .doneTag(doneTag));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;
  int evCyc [64]; int evOp [64]; int evBank [64]; int nEv = 0;
  int dnCyc [64]; int dnTag [64]; int nDn = 0;
  int e0, pushEdge;

  always @(negedge clk) begin
    if (rstN && cmdValid && nEv < 64) begin
      evCyc[nEv] = cyc; evOp[nEv] = int'(cmdOp); evBank[nEv] = int'(cmdBank); nEv++;
    end
    if (rstN && doneValid && nDn < 64) begin
      dnCyc[nDn] = cyc; dnTag[nDn] = int'(doneTag); nDn++;
    end
  end

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearLog();
    @(negedge clk); nEv = 0; nDn = 0;
  endtask

  task automatic push(bit wr, int bank, int row, int col, int tag);
    @(negedge clk);
    inValid = 1'b1; inWrite = wr; inBank = 2'(bank); inRow = 8'(row);
    inCol = 6'(col); inTag = 8'(tag);
    pushEdge = cyc + 1;
  endtask

  task automatic idleIn();
    @(negedge clk); inValid = 1'b0;
  endtask

  task automatic drain();
    repeat (40) @(negedge clk);
  endtask

  task automatic checkEv(string req, int k, int relCyc, int op, int bank);
    check({req, " cycle"}, evCyc[k] - e0, relCyc);
    check({req, " op"}, evOp[k], op);
    check({req, " bank"}, evBank[k], bank);
  endtask

  task automatic testReset();
    check("R1 cmdValid", int'(cmdValid), 0);
    check("R1 doneValid", int'(doneValid), 0);
    check("R1 inReady", int'(inReady), 1);
  endtask

  // R2 R3 R10: idle bank activate, then three row hits back to back
  task automatic testHits();
    clearLog();
    push(0, 0, 5, 1, 10); e0 = pushEdge;
    push(0, 0, 5, 2, 11); push(0, 0, 5, 3, 12); idleIn(); drain();
    check("R3 event count", nEv, 4);
    checkEv("R2 act", 0, 1, 0, 0);
    checkEv("R2 first col", 1, 4, 2, 0);
    checkEv("R3 second col", 2, 8, 2, 0);
    checkEv("R3 third col", 3, 12, 2, 0);
    check("R10 done count", nDn, 3);
    check("R10 done tag0", dnTag[0], 10);
    check("R10 done tag2", dnTag[2], 12);
    check("R10 done cycle", dnCyc[1], evCyc[2]);
  endtask

  // R8 hit over older conflict, then R5 precharge/activate timing
  task automatic testHitFirst();
    clearLog();
    push(0, 0, 5, 4, 20); e0 = pushEdge;
    push(0, 0, 9, 5, 21); push(0, 0, 5, 6, 22); idleIn(); drain();
    check("R8 event count", nEv, 5);
    checkEv("R8 hit col", 1, 5, 2, 0);
    checkEv("R5 pre", 2, 9, 1, 0);
    checkEv("R5 act", 3, 12, 0, 0);
    checkEv("R5 col", 4, 15, 2, 0);
    check("R8 served order", dnTag[1], 22);
    check("R8 served last", dnTag[2], 21);
  endtask

  // R8 idle-bank activate over older conflict
  task automatic testIdleFirst();
    clearLog();
    push(0, 0, 9, 7, 30); e0 = pushEdge;
    push(0, 0, 5, 8, 31); idleIn(); idleIn(); push(0, 3, 4, 9, 32); idleIn(); drain();
    check("R8 idle event count", nEv, 6);
    checkEv("R8 idle act first", 1, 5, 0, 3);
    checkEv("R8 conflict pre second", 2, 6, 1, 0);
    check("R8 idle order tag", dnTag[1], 32);
  endtask

  // R4 two idle banks
  task automatic testTwoBanks();
    clearLog();
    push(0, 1, 1, 1, 40); e0 = pushEdge;
    push(0, 2, 1, 2, 41); idleIn(); drain();
    checkEv("R4 act b1", 0, 1, 0, 1);
    checkEv("R4 act b2", 1, 2, 0, 2);
    checkEv("R4 col b1", 2, 4, 2, 1);
    checkEv("R4 col b2", 3, 8, 2, 2);
  endtask

  // R6 precharge during another bank's burst
  task automatic testOverlap();
    clearLog();
    push(0, 2, 1, 3, 50); e0 = pushEdge;
    push(0, 1, 7, 4, 51); idleIn(); drain();
    checkEv("R6 col b2", 0, 1, 2, 2);
    checkEv("R6 pre b1 inside burst", 1, 2, 1, 1);
    checkEv("R6 act b1", 2, 5, 0, 1);
    checkEv("R6 col b1", 3, 8, 2, 1);
  endtask

  // R7 turnaround in both orders
  task automatic testTurnaround();
    clearLog();
    push(1, 2, 1, 5, 60); e0 = pushEdge;
    push(0, 2, 1, 6, 61); idleIn(); drain();
    checkEv("R7 write", 0, 1, 3, 2);
    checkEv("R7 read after write", 1, 7, 2, 2);
    clearLog();
    push(0, 2, 1, 7, 62); e0 = pushEdge;
    push(1, 2, 1, 8, 63); idleIn(); drain();
    checkEv("R7 read", 0, 1, 2, 2);
    checkEv("R7 write after read", 1, 5, 3, 2);
  endtask

  // R9 R11 starved read among younger writes
  task automatic testStarve();
    clearLog();
    push(1, 2, 1, 0, 70); e0 = pushEdge;
    push(0, 2, 1, 1, 71); push(1, 2, 1, 2, 72); push(1, 2, 1, 3, 73);
    push(1, 2, 1, 4, 74); idleIn();
    check("R11 full", int'(inReady), 0);
    drain();
    check("R11 ready again", int'(inReady), 1);
    check("R9 col count", nEv, 5);
    checkEv("R9 w72", 1, 5, 3, 2);
    checkEv("R9 w73", 2, 9, 3, 2);
    checkEv("R9 starved read", 3, 15, 2, 2);
    checkEv("R9 last write", 4, 19, 3, 2);
    check("R9 tag order", dnTag[3], 71);
    check("R9 last tag", dnTag[4], 74);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testHits();
    testHitFirst();
    testIdleFirst();
    testTwoBanks();
    testOverlap();
    testTurnaround();
    testStarve();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule